// File: doc/BRIEF.md
# Word-Bus Access Sequencer with Alignment Trap

This block sits between a processor core and a 16-bit external data bus. The core issues one access at a time: a byte, a word or a longword, a read, a write or an instruction fetch. The sequencer maps the access onto one or two word-wide bus cycles, steers the byte lanes, waits for the bus acknowledge, and returns the result with a one-clock done pulse.

A longword always takes two bus cycles. The most significant half comes first at the given address and the least significant half follows at address plus two. Word and longword operands only need even addresses, so a longword at an address two above a multiple of four is accepted and runs at full speed. A word or longword request at an odd address, including a fetch, never reaches the bus. It ends at once with an address-error pulse that reports the faulting address, the direction and whether it was a fetch.

Top module: `word_bus_seq`

## Requirements
- R1: A word (size 1) or longword (size 2 or 3) request at an odd address starts no bus cycle. done_o and addr_err_o are both high in the first clock after the request is accepted.
- R2: An instruction fetch (fetch_i=1) of word or longword size at an odd address traps the same way, with err_fetch_o=1. A fetch is always a read, whatever we_i is.
- R3: A longword at an even address is legal whether or not the address is a multiple of four. It raises no address error.
- R4: A longword runs exactly two bus cycles. The first carries address A and write bits 31:16. The second carries A+2 and write bits 15:0.
- R5: With an acknowledge after W wait clocks, each bus cycle lasts W+1 clocks and one idle clock separates the two longword cycles. done_o therefore rises (W+1)+1 clocks after acceptance for a byte or word and 2(W+1)+2 clocks after for a longword, whatever the word alignment.
- R6: A byte (size 0) is legal at any address. At an even address only bus_ub_o is active and the data is on bus bits 15:8. At an odd address only bus_lb_o is active and the data is on bits 7:0. Write data bits 7:0 are driven on both lanes. Word and longword cycles drive both strobes.
- R7: Once raised, bus_cyc_o, bus_addr_o and bus_we_o stay unchanged until bus_ack_i is sampled high. After that bus_cyc_o is low for at least one clock.
- R8: done_o lasts exactly one clock. With addr_err_o, err_addr_o, err_we_o and err_fetch_o give the request's address, direction and fetch flag.
- R9: rdata_o changes only in the clock in which done_o is high after a read. A longword read gives {first word, second word}. A word or byte read is zero-extended. Writes and trapped requests leave rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken only while idle |
| size_i | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| addr_i | input | AW | Byte address of the operand |
| we_i | input | 1 | 1 write, 0 read |
| fetch_i | input | 1 | Instruction fetch (read only) |
| wdata_i | input | 32 | Write operand, right-aligned |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read operand |
| addr_err_o | output | 1 | Address error, coincides with done_o |
| err_addr_o | output | AW | Address of the access being reported |
| err_we_o | output | 1 | Direction of the access being reported |
| err_fetch_o | output | 1 | Reported access was a fetch |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_addr_o | output | AW | Bus byte address |
| bus_we_o | output | 1 | Bus write |
| bus_ub_o | output | 1 | Upper byte lane strobe (bits 15:8) |
| bus_lb_o | output | 1 | Lower byte lane strobe (bits 7:0) |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_ack_i | input | 1 | Bus cycle acknowledge |

## Verification
The alignment trap and completion share one clock: a rejected access must raise done_o and addr_err_o together, with no bus cycle before them. Read assembly and completion also coincide, because rdata_o may change only in the done clock. The bench sweeps every size at every offset from 0 to 7 for reads, writes and fetches, under 0, 1 and 2 wait clocks. At each completion it checks the error flag, the latency, the recorded bus beats and the read result together against values computed from the address.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int BUS_W = 16;
  localparam int OP_W  = 2 * BUS_W;
  localparam int BYTE_W = BUS_W / 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_GAP  = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wbs_align.sv
module wbs_align (
  input  logic [1:0] size_i,
  input  logic       addr_lsb_i,
  output logic       misalign_o,
  output logic       two_beats_o
);
  // any size above byte needs an even address
  assign misalign_o  = addr_lsb_i & (size_i != 2'd0);
  assign two_beats_o = size_i[1];
endmodule

// File: rtl/wbs_lane.sv
module wbs_lane
  import wbs_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic             addr_lsb_i,
  input  logic             beat_i,
  input  logic [OP_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0] bus_rd_i,
  output logic             ub_o,
  output logic             lb_o,
  output logic [BUS_W-1:0] bus_wd_o,
  output logic [BUS_W-1:0] beat_rd_o
);
  logic wide;
  assign wide = (size_i != 2'd0);
  assign ub_o = wide | ~addr_lsb_i;
  assign lb_o = wide | addr_lsb_i;

  always_comb begin
    if (size_i[1])
      bus_wd_o = beat_i ? wdata_i[BUS_W-1:0] : wdata_i[OP_W-1:BUS_W];
    else if (wide)
      bus_wd_o = wdata_i[BUS_W-1:0];
    else
      bus_wd_o = {wdata_i[BYTE_W-1:0], wdata_i[BYTE_W-1:0]};
  end

  always_comb begin
    if (wide)
      beat_rd_o = bus_rd_i;
    else if (addr_lsb_i)
      beat_rd_o = {{BYTE_W{1'b0}}, bus_rd_i[BYTE_W-1:0]};
    else
      beat_rd_o = {{BYTE_W{1'b0}}, bus_rd_i[BUS_W-1:BYTE_W]};
  end
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq
  import wbs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             misalign_i,
  input  logic             two_beats_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic             we_i,
  input  logic             fetch_i,
  input  logic [OP_W-1:0]  wdata_i,
  input  logic             ack_i,
  input  logic [BUS_W-1:0] beat_rd_i,
  output logic             cyc_o,
  output logic             beat_o,
  output logic             done_o,
  output logic             err_o,
  output logic [AW-1:0]    addr_o,
  output logic [1:0]       size_o,
  output logic             we_o,
  output logic             fetch_o,
  output logic [OP_W-1:0]  wdata_o,
  output logic [OP_W-1:0]  rdata_o
);
  seq_state_e       state_q;
  logic             beat_q, err_q, two_q, we_q, fetch_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       size_q;
  logic [OP_W-1:0]  wdata_q, rdata_q;
  logic [BUS_W-1:0] hi_q;
  logic             last_beat;

  assign last_beat = (beat_q == two_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      err_q   <= 1'b0;
      two_q   <= 1'b0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          size_q  <= size_i;
          we_q    <= we_i & ~fetch_i;
          fetch_q <= fetch_i;
          wdata_q <= wdata_i;
          err_q   <= misalign_i;
          two_q   <= two_beats_i;
          beat_q  <= 1'b0;
          state_q <= misalign_i ? ST_RESP : ST_BUS;
        end
        ST_BUS: if (ack_i) begin
          if (last_beat) begin
            if (!we_q)
              rdata_q <= two_q ? {hi_q, beat_rd_i} : {{BUS_W{1'b0}}, beat_rd_i};
            state_q <= ST_RESP;
          end else begin
            hi_q    <= beat_rd_i;
            beat_q  <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_BUS;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cyc_o   = (state_q == ST_BUS);
  assign done_o  = (state_q == ST_RESP);
  assign err_o   = done_o & err_q;
  assign beat_o  = beat_q;
  assign addr_o  = addr_q;
  assign size_o  = size_q;
  assign we_o    = we_q;
  assign fetch_o = fetch_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  // checker: bus cycles completed for the current access
  logic [1:0] beats_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        beats_seen_q <= '0;
    else if (state_q == ST_IDLE && req_i) beats_seen_q <= '0;
    else if (cyc_o && ack_i)            beats_seen_q <= beats_seen_q + 2'd1;
  end

  p_trap_no_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && misalign_i) |=> (err_o && !cyc_o));
  p_trap_zero_beats_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (beats_seen_q == 2'd0));
  p_long_two_beats_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_q) |-> (beats_seen_q == (two_q ? 2'd2 : 2'd1)));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rdata_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> (done_o && !we_q && !err_q));
endmodule

// File: rtl/word_bus_seq.sv
module word_bus_seq
  import wbs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic             fetch_i,
  input  logic [OP_W-1:0]  wdata_i,
  output logic             done_o,
  output logic [OP_W-1:0]  rdata_o,
  output logic             addr_err_o,
  output logic [AW-1:0]    err_addr_o,
  output logic             err_we_o,
  output logic             err_fetch_o,
  output logic             bus_cyc_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic             bus_we_o,
  output logic             bus_ub_o,
  output logic             bus_lb_o,
  output logic [BUS_W-1:0] bus_wdata_o,
  input  logic [BUS_W-1:0] bus_rdata_i,
  input  logic             bus_ack_i
);
  logic             misalign, two_beats, cyc, beat, ub, lb, we_q, fetch_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       size_q;
  logic [OP_W-1:0]  wdata_q;
  logic [BUS_W-1:0] bus_wd, beat_rd;

  wbs_align u_align (
    .size_i      (size_i),
    .addr_lsb_i  (addr_i[0]),
    .misalign_o  (misalign),
    .two_beats_o (two_beats)
  );

  wbs_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .misalign_i  (misalign),
    .two_beats_i (two_beats),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .we_i        (we_i),
    .fetch_i     (fetch_i),
    .wdata_i     (wdata_i),
    .ack_i       (bus_ack_i),
    .beat_rd_i   (beat_rd),
    .cyc_o       (cyc),
    .beat_o      (beat),
    .done_o      (done_o),
    .err_o       (addr_err_o),
    .addr_o      (addr_q),
    .size_o      (size_q),
    .we_o        (we_q),
    .fetch_o     (fetch_q),
    .wdata_o     (wdata_q),
    .rdata_o     (rdata_o)
  );

  wbs_lane u_lane (
    .size_i     (size_q),
    .addr_lsb_i (addr_q[0]),
    .beat_i     (beat),
    .wdata_i    (wdata_q),
    .bus_rd_i   (bus_rdata_i),
    .ub_o       (ub),
    .lb_o       (lb),
    .bus_wd_o   (bus_wd),
    .beat_rd_o  (beat_rd)
  );

  assign bus_cyc_o   = cyc;
  assign bus_addr_o  = addr_q + {{(AW-2){1'b0}}, beat, 1'b0};
  assign bus_we_o    = cyc & we_q;
  assign bus_ub_o    = cyc & ub;
  assign bus_lb_o    = cyc & lb;
  assign bus_wdata_o = bus_wd;
  assign err_addr_o  = addr_q;
  assign err_we_o    = we_q;
  assign err_fetch_o = fetch_q;

  p_hold_until_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !bus_ack_i) |=> (bus_cyc_o && $stable(bus_addr_o) && $stable(bus_we_o)));
  p_release_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_ack_i) |=> !bus_cyc_o);
  p_byte_one_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && size_q == 2'd0) |-> (bus_ub_o != bus_lb_o));
  p_err_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> done_o);
endmodule

// File: tb/word_bus_seq_test.sv
module word_bus_seq_test;
  localparam int AW = 24;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, fetch_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        done_o, addr_err_o, err_we_o, err_fetch_o;
  logic [31:0] rdata_o;
  logic [AW-1:0] err_addr_o, bus_addr_o;
  logic        bus_cyc_o, bus_we_o, bus_ub_o, bus_lb_o;
  logic [15:0] bus_wdata_o, bus_rdata_i;
  logic        bus_ack_i = 1'b0;

  int checks = 0, errors = 0;
  int waits = 0;
  int beat_total = 0;
  int hold_viol = 0;
  logic [AW-1:0] rec_addr [8];
  logic          rec_we [8], rec_ub [8], rec_lb [8];
  logic [15:0]   rec_wd [8];

  always #10 clk_i = ~clk_i;

  word_bus_seq #(.AW(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .size_i(size_i),
    .addr_i(addr_i), .we_i(we_i), .fetch_i(fetch_i), .wdata_i(wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .addr_err_o(addr_err_o),
    .err_addr_o(err_addr_o), .err_we_o(err_we_o), .err_fetch_o(err_fetch_o),
    .bus_cyc_o(bus_cyc_o), .bus_addr_o(bus_addr_o), .bus_we_o(bus_we_o),
    .bus_ub_o(bus_ub_o), .bus_lb_o(bus_lb_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
  );

  function automatic logic [15:0] memw(input logic [AW-1:0] a);
    return {a[8:1] ^ 8'h5A, a[8:1] + 8'h1F};
  endfunction

  assign bus_rdata_i = memw(bus_addr_o);

  // bus slave: acknowledge after `waits` clocks, record each beat, watch hold/release
  int wcnt = 0;
  logic prev_cyc = 1'b0, prev_ack = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic prev_we = 1'b0;
  always @(negedge clk_i) begin
    if (prev_ack && bus_cyc_o) hold_viol++;
    if (prev_cyc && !prev_ack && (!bus_cyc_o || bus_addr_o != prev_addr || bus_we_o != prev_we))
      hold_viol++;
    if (bus_cyc_o) begin
      if (wcnt == waits) begin
        bus_ack_i = 1'b1;
        wcnt = 0;
        rec_addr[beat_total % 8] = bus_addr_o;
        rec_we[beat_total % 8]   = bus_we_o;
        rec_ub[beat_total % 8]   = bus_ub_o;
        rec_lb[beat_total % 8]   = bus_lb_o;
        rec_wd[beat_total % 8]   = bus_wdata_o;
        beat_total++;
      end else begin
        bus_ack_i = 1'b0;
        wcnt++;
      end
    end else begin
      bus_ack_i = 1'b0;
      wcnt = 0;
    end
    prev_cyc  = bus_cyc_o;
    prev_ack  = bus_ack_i;
    prev_addr = bus_addr_o;
    prev_we   = bus_we_o;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  logic [31:0] exp_rdata = '0;

  task automatic run_op(input int sz, input logic [AW-1:0] base, input int mode, input logic [31:0] wd);
    int start, n, nb, exp_lat;
    bit is_err, is_wr;
    logic [15:0] exp_wd;
    @(negedge clk_i);
    req_i = 1'b1; size_i = sz[1:0]; addr_i = base;
    we_i = (mode != 0); fetch_i = (mode == 2); wdata_i = wd;
    start = beat_total;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; fetch_i = 1'b0; size_i = '0; addr_i = '0; wdata_i = '0;
    n = 1;
    while (!done_o && n < 60) begin @(negedge clk_i); n++; end
    is_err = (sz != 0) && base[0];
    is_wr  = (mode == 1);
    nb = (sz == 2) ? 2 : 1;
    chk("R8 done seen", {31'b0, done_o}, 32'd1);
    if (is_err) begin
      chk(mode == 2 ? "R2 fetch trap flag" : "R1 odd trap flag", {31'b0, addr_err_o}, 32'd1);
      chk("R1 no bus beats on trap", beat_total - start, 32'd0);
      chk("R5 trap latency", n, 32'd1);
      chk("R8 err_addr", {8'b0, err_addr_o}, {8'b0, base});
      chk("R8 err_we", {31'b0, err_we_o}, {31'b0, is_wr});
      chk("R2 err_fetch", {31'b0, err_fetch_o}, {31'b0, mode == 2});
    end else begin
      chk(sz == 2 ? "R3 legal long no trap" : "R6 legal no trap", {31'b0, addr_err_o}, 32'd0);
      chk("R4 beat count", beat_total - start, nb);
      exp_lat = nb * (1 + waits) + (nb - 1) + 1;
      chk("R5 latency", n, exp_lat);
      for (int i = 0; i < nb; i++) begin
        int k;
        k = (start + i) % 8;
        chk("R4 beat addr", {8'b0, rec_addr[k]}, {8'b0, base + AW'(2 * i)});
        chk("R2 beat dir", {31'b0, rec_we[k]}, {31'b0, is_wr});
        chk("R6 upper strobe", {31'b0, rec_ub[k]}, {31'b0, (sz != 0) || !base[0]});
        chk("R6 lower strobe", {31'b0, rec_lb[k]}, {31'b0, (sz != 0) || base[0]});
        if (is_wr) begin
          if (sz == 2)      exp_wd = (i == 0) ? wd[31:16] : wd[15:0];
          else if (sz == 1) exp_wd = wd[15:0];
          else              exp_wd = {wd[7:0], wd[7:0]};
          chk(sz == 2 ? "R4 beat wdata" : "R6 beat wdata", {16'b0, rec_wd[k]}, {16'b0, exp_wd});
        end
      end
      if (!is_wr) begin
        if (sz == 2)      exp_rdata = {memw(base), memw(base + 2)};
        else if (sz == 1) exp_rdata = {16'b0, memw(base)};
        else              exp_rdata = {24'b0, base[0] ? memw(base)[7:0] : memw(base)[15:8]};
      end
    end
    chk("R9 rdata", rdata_o, exp_rdata);
    @(negedge clk_i);
    chk("R8 done one clock", {30'b0, done_o, addr_err_o}, 32'd0);
    chk("R9 rdata held", rdata_o, exp_rdata);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("reset cyc", {31'b0, bus_cyc_o}, 32'd0);
    chk("reset done", {31'b0, done_o}, 32'd0);
    chk("reset err", {31'b0, addr_err_o}, 32'd0);
    chk("reset rdata", rdata_o, 32'd0);
    rst_ni = 1'b1;
    for (int w = 0; w < 3; w++) begin
      waits = w;
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 8; off++)
          for (int mode = 0; mode < 3; mode++)
            run_op(sz, AW'(24'h012340 + off + 16 * w),
                   mode, {8'hA0 + 8'(off), 8'hC3 ^ 8'(sz), 8'h10 + 8'(w), 8'h5E + 8'(mode)});
    end
    chk("R7 hold and release", hold_viol, 32'd0);
    summary();
  end
endmodule